// File: doc/BRIEF.md
# Register Rename Map with Free List

This block renames architectural destination registers onto a larger pool of physical registers. Each cycle it accepts a group of up to `LANES` decoded instructions. For every lane that writes a register it hands out a fresh physical register taken from a free list, and it records the new mapping in the logical-to-physical table. It translates both source operands through the table. When an older lane in the same group has just redefined a source, the source takes that lane's new register. Each lane also returns the physical register that its destination held before. The pipeline carries this old register to commit, where it is handed back to the free list. A register is therefore reclaimed only once a later redefinition of the same logical register has retired.

For speculation, the block keeps `NUM_CKPT` checkpoint slots. Each slot stores a whole copy of the mapping table together with the free-list read position. The decoder saves a slot when it renames a conditional branch. If the branch was predicted correctly, the slot is simply left to be overwritten later. On a mispredict, a restore copies the slot back into the map and rolls the free-list read position back. Every register allocated after the checkpoint thereby becomes free again in one cycle.

Top module: `rn_rename_map`

## Requirements
- R1: After reset, logical register i maps to physical register i. The free list holds physical registers NUM_LOG to NUM_PHYS-1, and hands them out in ascending order.
- R2: Free registers are handed out first-in first-out: the oldest free entry goes to the lowest-numbered allocating lane. Lanes with `rn_valid` and `rn_has_dst` high allocate.
- R3: A group is accepted as a whole. `rn_ready` is low when the number of allocating lanes exceeds the number of free registers counted at the start of the cycle. A group with no allocating lane is accepted even when the list is empty.
- R4: A source operand reads the current map. If an older allocating lane in the same group names that source as its destination, the youngest such lane's new register is used instead.
- R5: `rn_old_p` gives the mapping the lane's destination had just before that lane. The same in-group override as R4 applies, so a lane that follows another lane writing the same destination gets that lane's new register.
- R6: When several lanes of one group write the same logical register, the youngest lane's register is the one left in the map.
- R7: A commit (`cm_valid` with `cm_preg`) appends the register at the tail of the free list. It cannot be allocated before the next cycle.
- R8: `br_save` stores into slot `br_slot` the map including the same-cycle renames, and the free-list position after the same-cycle allocations. A save in a restore cycle is ignored.
- R9: `br_restore` reloads the map from slot `br_rslot` and rolls the free-list head back to that slot's position. It holds `rn_ready` low in that cycle. A commit in the same cycle is still appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | LANES | Lane holds an instruction |
| rn_has_dst | input | LANES | Lane writes a destination register |
| rn_dst | input | LANES x LW | Logical destination per lane |
| rn_src_a | input | LANES x LW | Logical first source per lane |
| rn_src_b | input | LANES x LW | Logical second source per lane |
| rn_ready | output | 1 | Group accepted this cycle (when any lane valid) |
| rn_new_p | output | LANES x PW | Newly allocated physical destination |
| rn_old_p | output | LANES x PW | Previous physical mapping of the destination |
| rn_src_a_p | output | LANES x PW | Physical first source |
| rn_src_b_p | output | LANES x PW | Physical second source |
| cm_valid | input | 1 | A retiring instruction frees a register |
| cm_preg | input | PW | Physical register to free |
| br_save | input | 1 | Take a checkpoint |
| br_slot | input | CW | Slot written by a save |
| br_restore | input | 1 | Roll back to a checkpoint |
| br_rslot | input | CW | Slot read by a restore |

## Verification
The bench goes after three groups of cases.

The first is in-group dependencies: a source that names an older lane's destination, and two lanes writing the same register. A design without the bypass would hand a consumer the stale register. A design that let the older lane win would leak a register and point later readers at the wrong one.

The second is the free list at its edge. The bench drains the list, then offers a one-register group, a two-register group with one register free, a group with no destination, and a commit that lands in the same cycle as a request. A design that counted the same-cycle commit, or allocated lanes partially, would show a wrong `rn_ready` there.

The third is rollback. The bench saves a checkpoint in the same cycle as a rename, renames further, then restores with a commit in the same cycle. It then checks that the following renames see the checkpointed map and receive the very registers that had been rolled back.

// File: rtl/rn_pkg.sv
package rn_pkg;

  // number of set bits in a lane mask
  function automatic int unsigned mask_ones(input logic [31:0] m);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (m[i]) n++;
    end
    return n;
  endfunction

  // number of set bits strictly below position lane: the free-list offset of that lane
  function automatic int unsigned mask_ones_below(input logic [31:0] m, input int unsigned lane);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (m[i] && (i < lane)) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  parameter int LANES    = 2,
  parameter int NUM_CKPT = 4,
  localparam int PW   = $clog2(NUM_PHYS),
  localparam int QW   = PW + 1,
  localparam int CW   = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
  localparam int INIT = NUM_PHYS - NUM_LOG
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [QW-1:0]             pop_cnt,
  input  logic                      push_en,
  input  logic [PW-1:0]             push_preg,
  input  logic                      save,
  input  logic [CW-1:0]             save_slot,
  input  logic                      restore,
  input  logic [CW-1:0]             restore_slot,
  output logic [LANES-1:0][PW-1:0]  head_regs,
  output logic [QW-1:0]             free_cnt
);
  // ring of depth NUM_PHYS (power of two): pointers carry one wrap bit
  logic [PW-1:0] ring_q [NUM_PHYS];
  logic [QW-1:0] head_q, tail_q, head_nx;
  logic [QW-1:0] ck_head_q [NUM_CKPT];

  assign free_cnt = tail_q - head_q;
  assign head_nx  = restore ? ck_head_q[restore_slot] : head_q + pop_cnt;

  for (genvar l = 0; l < LANES; l++) begin : g_peek
    assign head_regs[l] = ring_q[head_q[PW-1:0] + PW'(l)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < NUM_PHYS; j++) begin
        ring_q[j] <= (j < INIT) ? PW'(NUM_LOG + j) : '0;
      end
      for (int c = 0; c < NUM_CKPT; c++) ck_head_q[c] <= '0;
      head_q <= '0;
      tail_q <= QW'(INIT);
    end else begin
      head_q <= head_nx;
      if (push_en) begin
        ring_q[tail_q[PW-1:0]] <= push_preg;
        tail_q <= tail_q + QW'(1);
      end
      if (save && !restore) ck_head_q[save_slot] <= head_nx;
    end
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  parameter int LANES    = 2,
  parameter int NUM_CKPT = 4,
  localparam int LW = $clog2(NUM_LOG),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             wr_en,
  input  logic [LANES-1:0][LW-1:0]     wr_log,
  input  logic [LANES-1:0][PW-1:0]     wr_phys,
  input  logic                         save,
  input  logic [CW-1:0]                save_slot,
  input  logic                         restore,
  input  logic [CW-1:0]                restore_slot,
  output logic [NUM_LOG-1:0][PW-1:0]   map_q
);
  logic [NUM_LOG-1:0][PW-1:0] map_nx;
  logic [NUM_LOG-1:0][PW-1:0] ck_q [NUM_CKPT];

  // younger lanes are applied last so they win on a shared destination
  always_comb begin
    map_nx = map_q;
    if (restore) begin
      map_nx = ck_q[restore_slot];
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_en[l]) map_nx[wr_log[l]] = wr_phys[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LOG; i++) map_q[i] <= PW'(i);
      for (int c = 0; c < NUM_CKPT; c++) begin
        for (int i = 0; i < NUM_LOG; i++) ck_q[c][i] <= PW'(i);
      end
    end else begin
      map_q <= map_nx;
      if (save && !restore) ck_q[save_slot] <= map_nx;
    end
  end
endmodule

// File: rtl/rn_rename_map.sv
module rn_rename_map
  import rn_pkg::*;
#(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  parameter int LANES    = 2,
  parameter int NUM_CKPT = 4,
  localparam int LW  = $clog2(NUM_LOG),
  localparam int PW  = $clog2(NUM_PHYS),
  localparam int CW  = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
  localparam int QW  = PW + 1,
  localparam int LIW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          rn_valid,
  input  logic [LANES-1:0]          rn_has_dst,
  input  logic [LANES-1:0][LW-1:0]  rn_dst,
  input  logic [LANES-1:0][LW-1:0]  rn_src_a,
  input  logic [LANES-1:0][LW-1:0]  rn_src_b,
  output logic                      rn_ready,
  output logic [LANES-1:0][PW-1:0]  rn_new_p,
  output logic [LANES-1:0][PW-1:0]  rn_old_p,
  output logic [LANES-1:0][PW-1:0]  rn_src_a_p,
  output logic [LANES-1:0][PW-1:0]  rn_src_b_p,
  input  logic                      cm_valid,
  input  logic [PW-1:0]             cm_preg,
  input  logic                      br_save,
  input  logic [CW-1:0]             br_slot,
  input  logic                      br_restore,
  input  logic [CW-1:0]             br_rslot
);
  // named internal events, also watched by the checker
  logic [LANES-1:0]           want_mask;
  logic [LANES-1:0]           alloc_mask;
  logic [QW-1:0]              need;
  logic [QW-1:0]              free_cnt;
  logic [QW-1:0]              pop_cnt;
  logic                       accept;
  logic [LANES-1:0][PW-1:0]   head_regs;
  logic [NUM_LOG-1:0][PW-1:0] map_q;

  assign want_mask  = rn_valid & rn_has_dst;
  assign need       = QW'(mask_ones(32'(want_mask)));
  assign rn_ready   = !br_restore && (need <= free_cnt);
  assign accept     = rn_ready && (|rn_valid);
  assign alloc_mask = accept ? want_mask : '0;
  assign pop_cnt    = accept ? need : '0;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rn_new_p[l] = head_regs[LIW'(mask_ones_below(32'(want_mask), l))];
    end
  end

  // translation with in-group override from older allocating lanes
  always_comb begin
    logic [PW-1:0] a_v, b_v, o_v;
    for (int l = 0; l < LANES; l++) begin
      a_v = map_q[rn_src_a[l]];
      b_v = map_q[rn_src_b[l]];
      o_v = map_q[rn_dst[l]];
      for (int k = 0; k < l; k++) begin
        if (want_mask[k] && rn_dst[k] == rn_src_a[l]) a_v = rn_new_p[k];
        if (want_mask[k] && rn_dst[k] == rn_src_b[l]) b_v = rn_new_p[k];
        if (want_mask[k] && rn_dst[k] == rn_dst[l])   o_v = rn_new_p[k];
      end
      rn_src_a_p[l] = a_v;
      rn_src_b_p[l] = b_v;
      rn_old_p[l]   = o_v;
    end
  end

  rn_free_list #(
    .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .LANES(LANES), .NUM_CKPT(NUM_CKPT)
  ) u_free (
    .clk          (clk),
    .rst_n        (rst_n),
    .pop_cnt      (pop_cnt),
    .push_en      (cm_valid),
    .push_preg    (cm_preg),
    .save         (br_save),
    .save_slot    (br_slot),
    .restore      (br_restore),
    .restore_slot (br_rslot),
    .head_regs    (head_regs),
    .free_cnt     (free_cnt)
  );

  rn_map_table #(
    .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .LANES(LANES), .NUM_CKPT(NUM_CKPT)
  ) u_map (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (alloc_mask),
    .wr_log       (rn_dst),
    .wr_phys      (rn_new_p),
    .save         (br_save),
    .save_slot    (br_slot),
    .restore      (br_restore),
    .restore_slot (br_rslot),
    .map_q        (map_q)
  );
endmodule

// File: rtl/rn_rename_map_chk.sv
module rn_rename_map_chk #(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 16,
  parameter int LANES    = 2,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int QW = PW + 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rn_ready,
  input logic                      br_restore,
  input logic                      cm_valid,
  input logic                      accept,
  input logic [QW-1:0]             need,
  input logic [QW-1:0]             free_cnt,
  input logic [LANES-1:0]          alloc_mask,
  input logic [LANES-1:0][PW-1:0]  rn_new_p
);
  a_r3_short_list_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (need > free_cnt) |-> !rn_ready);

  a_r9_restore_blocks_rename: assert property (@(posedge clk) disable iff (!rst_n)
    br_restore |-> !rn_ready);

  a_r7_commit_grows_list: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !br_restore && !accept) |=> (free_cnt == $past(free_cnt) + QW'(1)));

  a_r2_allocation_shrinks_list: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cm_valid) |=> (free_cnt == $past(free_cnt) - $past(need)));

  a_r1_list_within_pool: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= QW'(NUM_PHYS - NUM_LOG));

  if (LANES >= 2) begin : g_pair
    a_r2_lanes_get_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_mask[0] && alloc_mask[1]) |-> (rn_new_p[0] != rn_new_p[1]));
  end
endmodule

bind rn_rename_map rn_rename_map_chk #(
  .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .LANES(LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rn_ready   (rn_ready),
  .br_restore (br_restore),
  .cm_valid   (cm_valid),
  .accept     (accept),
  .need       (need),
  .free_cnt   (free_cnt),
  .alloc_mask (alloc_mask),
  .rn_new_p   (rn_new_p)
);

// File: tb/test_rn_rename_map.sv
module test_rn_rename_map;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]      rn_valid, rn_has_dst;
  logic [1:0][2:0] rn_dst, rn_src_a, rn_src_b;
  logic            rn_ready;
  logic [1:0][3:0] rn_new_p, rn_old_p, rn_src_a_p, rn_src_b_p;
  logic            cm_valid, br_save, br_restore;
  logic [3:0]      cm_preg;
  logic [1:0]      br_slot, br_rslot;

  rn_rename_map i_rn_rename_map (
    .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_has_dst(rn_has_dst),
    .rn_dst(rn_dst), .rn_src_a(rn_src_a), .rn_src_b(rn_src_b), .rn_ready(rn_ready),
    .rn_new_p(rn_new_p), .rn_old_p(rn_old_p), .rn_src_a_p(rn_src_a_p),
    .rn_src_b_p(rn_src_b_p), .cm_valid(cm_valid), .cm_preg(cm_preg),
    .br_save(br_save), .br_slot(br_slot), .br_restore(br_restore), .br_rslot(br_rslot)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    string  tag;
    bit     rdy;
    bit     acc;
    bit [1:0] v;
    bit [1:0] hd;
    int     newp[2];
    int     oldp[2];
    int     sa[2];
    int     sb[2];
  } exp_t;
  exp_t exp_q[$];

  // stimulus staged by the scenario, applied at the next falling edge
  bit pv[2], ph[2];
  int pd[2], pa[2], pb[2];
  bit psave, prest, pcm;
  int pss, prs, pcp;

  // reference model: sequential per-lane walk over a map and an ordered free queue
  int mmap[8];
  int fq[$];
  int ckmap[4][8];
  int cklist[4][$];
  bit record_old = 0;
  int pend_old[$];

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clr();
    for (int l = 0; l < 2; l++) begin
      pv[l] = 0; ph[l] = 0; pd[l] = 0; pa[l] = 0; pb[l] = 0;
    end
    psave = 0; prest = 0; pcm = 0; pss = 0; prs = 0; pcp = 0;
  endtask

  task automatic lane(int l, bit v, bit h, int d, int a, int b);
    pv[l] = v; ph[l] = h; pd[l] = d; pa[l] = a; pb[l] = b;
  endtask

  // driver: applies one cycle, predicts the outputs, queues them, advances the model
  task automatic step(string tag);
    exp_t e;
    int tmap[8];
    int need, idx;
    @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      rn_valid[l] = pv[l]; rn_has_dst[l] = ph[l];
      rn_dst[l] = 3'(pd[l]); rn_src_a[l] = 3'(pa[l]); rn_src_b[l] = 3'(pb[l]);
    end
    cm_valid = pcm; cm_preg = 4'(pcp);
    br_save = psave; br_slot = 2'(pss);
    br_restore = prest; br_rslot = 2'(prs);

    need = 0;
    for (int l = 0; l < 2; l++) if (pv[l] && ph[l]) need++;
    e.tag = tag;
    e.rdy = !prest && (need <= fq.size());
    e.acc = e.rdy && (pv[0] || pv[1]);
    tmap = mmap;
    idx = 0;
    for (int l = 0; l < 2; l++) begin
      e.v[l] = pv[l]; e.hd[l] = ph[l];
      e.sa[l] = tmap[pa[l]]; e.sb[l] = tmap[pb[l]]; e.oldp[l] = tmap[pd[l]];
      e.newp[l] = 0;
      if (pv[l] && ph[l] && idx < fq.size()) begin
        e.newp[l] = fq[idx];
        idx++;
        tmap[pd[l]] = e.newp[l];
      end
    end
    exp_q.push_back(e);

    if (e.acc) begin
      mmap = tmap;
      for (int l = 0; l < 2; l++) begin
        if (pv[l] && ph[l]) begin
          int r;
          r = fq.pop_front();
          for (int c = 0; c < 4; c++) cklist[c].push_back(r);
          if (record_old) pend_old.push_back(e.oldp[l]);
        end
      end
    end
    if (prest) begin
      int n;
      mmap = ckmap[prs];
      n = cklist[prs].size();
      for (int i = n - 1; i >= 0; i--) fq.push_front(cklist[prs][i]);
      for (int c = 0; c < 4; c++) begin
        if (c != prs) begin
          for (int i = 0; i < n && cklist[c].size() > 0; i++) void'(cklist[c].pop_back());
        end
      end
      cklist[prs].delete();
    end
    if (pcm) fq.push_back(pcp);
    if (psave && !prest) begin
      ckmap[pss] = mmap;
      cklist[pss].delete();
    end
    clr();
  endtask

  // monitor: compares the design's outputs in the middle of the low phase
  always @(negedge clk) begin
    #2;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      cmp(e.tag, "ready", int'(rn_ready), int'(e.rdy));
      if (e.acc) begin
        for (int l = 0; l < 2; l++) begin
          if (e.v[l]) begin
            cmp(e.tag, $sformatf("lane%0d src_a", l), int'(rn_src_a_p[l]), e.sa[l]);
            cmp(e.tag, $sformatf("lane%0d src_b", l), int'(rn_src_b_p[l]), e.sb[l]);
            if (e.hd[l]) begin
              cmp(e.tag, $sformatf("lane%0d new", l), int'(rn_new_p[l]), e.newp[l]);
              cmp(e.tag, $sformatf("lane%0d old", l), int'(rn_old_p[l]), e.oldp[l]);
            end
          end
        end
      end
    end
  end

  bit done = 0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 8; i++) mmap[i] = i;
    for (int i = 8; i < 16; i++) fq.push_back(i);
    for (int c = 0; c < 4; c++) ckmap[c] = mmap;
    clr();
    rn_valid = 0; rn_has_dst = 0; rn_dst = 0; rn_src_a = 0; rn_src_b = 0;
    cm_valid = 0; cm_preg = 0; br_save = 0; br_slot = 0; br_restore = 0; br_rslot = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 identity map and first free registers; R4 lane1 reads lane0's fresh r1
    lane(0, 1, 1, 1, 0, 7); lane(1, 1, 1, 2, 1, 2);
    step("R1 R4 R5 reset map and in-group source");
    // R6 both lanes write r3; R5 lane1 old is lane0's new
    lane(0, 1, 1, 3, 3, 3); lane(1, 1, 1, 3, 3, 0);
    step("R6 R5 same destination in group");
    lane(0, 1, 0, 0, 3, 1);
    step("R6 youngest lane left in map");
    // R8 checkpoint in the same cycle as a rename
    lane(0, 1, 1, 4, 2, 4); psave = 1; pss = 1;
    step("R8 save with same-cycle rename");
    lane(0, 1, 1, 4, 4, 0); lane(1, 1, 1, 5, 4, 5);
    step("R2 speculative renames");
    // R9 restore blocks rename; commit of r1's old register lands too
    lane(0, 1, 1, 6, 0, 0); prest = 1; prs = 1; pcm = 1; pcp = 1;
    step("R9 restore cycle");
    lane(0, 1, 1, 4, 4, 0); lane(1, 1, 1, 5, 5, 4);
    step("R9 map and list rolled back");
    lane(0, 1, 1, 6, 6, 0); lane(1, 1, 1, 7, 7, 0);
    step("R2 drain list");
    lane(0, 1, 1, 1, 0, 0);
    step("R3 empty list stalls");
    lane(0, 1, 0, 0, 1, 2);
    step("R3 no-destination group accepted when empty");
    lane(0, 1, 1, 1, 1, 0); pcm = 1; pcp = 2;
    step("R7 same-cycle commit not usable");
    lane(0, 1, 1, 1, 0, 0); lane(1, 1, 1, 2, 0, 0);
    step("R3 whole group stalls with one free");
    lane(0, 1, 1, 1, 1, 0);
    step("R7 committed register reused");

    // streaming phase: random groups, commits of the recorded old registers
    record_old = 1;
    lf = 16'hACE1;
    for (int n = 0; n < 80; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lane(0, lf[0], lf[1], int'(lf[4:2]), int'(lf[7:5]), int'(lf[10:8]));
      lane(1, lf[11], lf[12], int'(lf[15:13]), int'(lf[3:1]), int'(lf[6:4]));
      if (pend_old.size() > 0 && (lf[9] || pend_old.size() > 4)) begin
        pcm = 1; pcp = pend_old.pop_front();
      end
      step("R2 R4 stream");
    end
    @(negedge clk);
    #4;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule